// File: doc/BRIEF.md
# Reference Switch Phase Corrector

This block sits between the reference selector and the phase detector of a clock synthesis loop. It takes two reference waveforms and a select line, and emits a virtual reference. The virtual reference is a one-cycle pulse for every accepted falling edge of the chosen reference. When the select line moves to the other reference, the block holds the phase of the virtual reference steady. It does so by delaying the edges of the newly chosen reference, so the downstream loop does not see a step in phase.

While correction is enabled, the block keeps a running count of master-clock cycles from the latest falling edge of the unselected reference to each falling edge of the selected one. It also keeps the distance between consecutive selected edges, which is the reference period. On a switch, the stored offset is added to the current delay, wrapped by that period. Every later edge of the new reference is then re-emitted after the new delay. Pulling the correction enable low turns the block into a plain edge-to-pulse path and clears the accumulated delay. When enable returns, edges are aligned again starting from zero delay.

Top module: `ref_phase_corrector`

## Requirements
- R1: While `rst_n` is low, `vref` is low. After reset the delay is zero, so the first selected falling edge produces a pulse two cycles after the edge is driven.
- R2: While `corr_en` is low, each falling edge of the selected reference gives one `vref` pulse, one cycle wide, two clock cycles after the edge is driven, whatever delay was stored before.
- R3: While `corr_en` is high and no switch occurs, each selected falling edge gives one single-cycle `vref` pulse, 2 + D cycles after the edge is driven, where D is the current delay.
- R4: The measured offset is the number of cycles from the most recent falling edge of the unselected reference to the falling edge of the selected reference. It is zero when both references fall in the same cycle.
- R5: On a change of `sel` while `corr_en` is high, D becomes (D + offset) modulo P. P is the cycle count between the last two falling edges of the previously selected reference.
- R6: A change of `sel` while `corr_en` is low leaves D at zero.
- R7: Pulling `corr_en` low clears D and discards a pulse that is still pending. After `corr_en` returns high, edges are emitted with no added delay until the next switch.
- R8: Falling edges of the unselected reference never produce a `vref` pulse.
- R9: When a pending pulse of the old reference and the first pulse of the new reference fall in the same cycle, `vref` shows a single pulse in that cycle.
- R10: `sel` = 0 selects `ref_a`; `sel` = 1 selects `ref_b`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_a | input | 1 | Reference waveform chosen when `sel` is 0 |
| ref_b | input | 1 | Reference waveform chosen when `sel` is 1 |
| sel | input | 1 | Reference select |
| corr_en | input | 1 | High: measure and correct; low: bypass and clear delay |
| vref | output | 1 | Virtual reference pulse, one clock wide |

## Verification
The two functions that can meet in one cycle are the delayed emission of an edge captured before a switch and the first edge of the newly selected reference. When the offset wraps the delay back to zero, both fire in the same cycle. The bench provokes this by switching back to the first reference after a round trip whose offsets add up to one full period. The old reference's pending pulse then lands exactly on the new reference's first edge. The scoreboard expects exactly one pulse in that cycle and flags both a missing pulse and a doubled or extra pulse.

// File: rtl/ref_phase_corrector.sv
module ref_phase_corrector #(
  parameter int CNT_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_a,
  input  logic ref_b,
  input  logic sel,
  input  logic corr_en,
  output logic vref
);

  localparam logic [CNT_W-1:0] CNT_SAT = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic a_s, a_p, b_s, b_p, sel_s, sel_q, en_s, pend_q;
  logic [CNT_W-1:0] cnt_a, cnt_b, off_q, per_q, dly_q, dcnt_q;
  logic [CNT_W-1:0] off_now, per_now, dly_sw;
  logic [CNT_W:0]   sum;

  wire fall_a   = a_p & ~a_s;
  wire fall_b   = b_p & ~b_s;
  wire fall_sel = sel_q ? fall_b : fall_a;
  wire fall_alt = sel_q ? fall_a : fall_b;
  wire swap     = sel_s ^ sel_q;
  wire [CNT_W-1:0] cnt_sel = sel_q ? cnt_b : cnt_a;
  wire [CNT_W-1:0] cnt_alt = sel_q ? cnt_a : cnt_b;

  wire fire = en_s ? ((fall_sel && dly_q == '0) || (pend_q && dcnt_q == CNT_ONE))
                   : fall_sel;

  // offset and period as seen in this cycle, including a capture now
  always_comb begin
    off_now = off_q;
    per_now = per_q;
    if (fall_sel) begin
      off_now = (fall_alt || cnt_alt == CNT_SAT) ? '0 : cnt_alt;
      per_now = (cnt_sel == CNT_SAT) ? '0 : cnt_sel;
    end
    sum = {1'b0, dly_q} + {1'b0, off_now};
    if (per_now != '0 && sum >= {1'b0, per_now})
      dly_sw = CNT_W'(sum - {1'b0, per_now});
    else
      dly_sw = CNT_W'(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_s <= 1'b0; a_p <= 1'b0; b_s <= 1'b0; b_p <= 1'b0;
      sel_s <= 1'b0; sel_q <= 1'b0; en_s <= 1'b0;
      cnt_a <= CNT_SAT; cnt_b <= CNT_SAT;
      off_q <= '0; per_q <= '0; dly_q <= '0;
      pend_q <= 1'b0; dcnt_q <= '0;
      vref <= 1'b0;
    end else begin
      a_s <= ref_a; a_p <= a_s;
      b_s <= ref_b; b_p <= b_s;
      sel_s <= sel; sel_q <= sel_s;
      en_s <= corr_en;
      vref <= fire;

      cnt_a <= fall_a ? CNT_ONE : (cnt_a == CNT_SAT ? CNT_SAT : cnt_a + CNT_ONE);
      cnt_b <= fall_b ? CNT_ONE : (cnt_b == CNT_SAT ? CNT_SAT : cnt_b + CNT_ONE);

      if (fall_sel) begin
        off_q <= off_now;
        per_q <= per_now;
      end

      if (!en_s)     dly_q <= '0;
      else if (swap) dly_q <= dly_sw;

      if (!en_s) begin
        pend_q <= 1'b0;
      end else if (fall_sel) begin
        pend_q <= (dly_q != '0);
        dcnt_q <= dly_q;
      end else if (pend_q) begin
        if (dcnt_q == CNT_ONE) pend_q <= 1'b0;
        else                   dcnt_q <= dcnt_q - CNT_ONE;
      end
    end
  end

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_s && fall_sel) |=> vref) else $error("bypass edge lost"); // R2
  AST_CLEAR_ON_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> (dly_q == '0 && !pend_q)) else $error("delay not cleared"); // R7
  AST_DELAY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_s && !swap) |=> $stable(dly_q)) else $error("delay moved without switch"); // R3
  AST_ALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (en_s && fall_alt && !fall_sel && !pend_q) |=> !vref) else $error("alternate edge leaked"); // R8
  AST_PEND_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> dcnt_q != '0) else $error("pending with empty count"); // R3

endmodule

// File: tb/sim_ref_phase_corrector.sv
module sim_ref_phase_corrector;
  logic clk = 1'b0, rst_n = 1'b0, ref_a = 1'b1, ref_b = 1'b1, sel = 1'b0, corr_en = 1'b1;
  logic vref;

  always #5 clk = ~clk;

  ref_phase_corrector u0 (.clk(clk), .rst_n(rst_n), .ref_a(ref_a), .ref_b(ref_b),
                          .sel(sel), .corr_en(corr_en), .vref(vref));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int exp_q[$];
  string tag_q[$];
  int n_cmp = 0, n_bad = 0, n_unexp = 0;
  int P, pa, pb, dm, t;
  bit bsel, ben;

  task automatic chk(bit ok, string tag, int act, int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // monitor: pops the scoreboard as pulses appear
  always @(negedge clk) if (rst_n) begin
    if (vref) begin
      if (exp_q.size() > 0 && exp_q[0] == cyc) begin
        chk(1'b1, tag_q[0], 1, 1);
        void'(exp_q.pop_front()); void'(tag_q.pop_front());
      end else begin
        n_unexp++;
        chk(1'b0, "R8 unexpected pulse", 1, 0);
      end
    end else if (exp_q.size() > 0 && exp_q[0] == cyc) begin
      chk(1'b0, {tag_q[0], " missing pulse"}, 0, 1);
      void'(exp_q.pop_front()); void'(tag_q.pop_front());
    end
  end

  // driver: one cycle of stimulus, pushes expected pulse cycles
  task automatic step(string tag);
    int e;
    bit fa, fb;
    @(negedge clk);
    fa = (t % P) == pa;
    fb = (t % P) == pb;
    if (bsel ? fb : fa) begin
      e = cyc + 2 + (ben ? dm : 0);
      if (exp_q.size() > 0 && exp_q[$] == e) tag_q[$] = "R9";
      else begin exp_q.push_back(e); tag_q.push_back(tag); end
    end
    ref_a = (((t + P - pa) % P) >= P / 2);
    ref_b = (((t + P - pb) % P) >= P / 2);
    t++;
  endtask

  task automatic run_to(int tt, string tag);
    while (t < tt) step(tag);
  endtask

  task automatic switch_to(bit s);
    int off;
    if (ben) begin
      off = bsel ? (pb - pa + P) % P : (pa - pb + P) % P;
      dm = (dm + off) % P;
    end
    bsel = s;
    sel = s;
  endtask

  task automatic en_off();
    ben = 1'b0; dm = 0; corr_en = 1'b0;
    while (exp_q.size() > 0 && exp_q[$] >= cyc + 2) begin
      void'(exp_q.pop_back()); void'(tag_q.pop_back());
    end
  endtask

  task automatic start(int per, int phase_a, int phase_b);
    rst_n = 1'b0; ref_a = 1'b1; ref_b = 1'b1; sel = 1'b0; corr_en = 1'b1;
    P = per; pa = phase_a; pb = phase_b; dm = 0; t = 0; bsel = 1'b0; ben = 1'b1;
    repeat (4) @(negedge clk);
    chk(vref == 1'b0, "R1 reset output", int'(vref), 0);
    rst_n = 1'b1;
  endtask

  task automatic finish_scn();
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 pending expectations", exp_q.size(), 0);
    chk(n_unexp == 0, "R8 stray pulses", n_unexp, 0);
  endtask

  initial begin
    start(1000, 100, 400);
    run_to(2700, "R1/R3/R10");
    switch_to(1'b1);
    run_to(5050, "R5");
    switch_to(1'b0);
    run_to(6700, "R5");
    switch_to(1'b1);
    run_to(7800, "R5");
    en_off();
    run_to(8700, "R2");
    switch_to(1'b0);
    run_to(9300, "R6");
    ben = 1'b1; corr_en = 1'b1;
    run_to(10700, "R7");
    switch_to(1'b1);
    run_to(12300, "R5");
    finish_scn();

    start(600, 200, 200);
    run_to(1500, "R3");
    switch_to(1'b1);
    run_to(3000, "R4");
    finish_scn();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule